// File: doc/BRIEF.md
# Multiplexed GPIO Line Controller

This block owns sixteen general-purpose pad lines and the registers that steer them. Software reaches it through a narrow 16-bit register bus with byte offsets on 32-bit boundaries. Each line has a 2-bit routing code that picks what drives the pad. The code can pick the controller's own output-data register, one of two alternate sources that carry their own enable, or an input-only alternate that never drives. A per-line direction mask, where a set bit means input, overrides every routing choice and keeps the pad released.

Pad input levels pass through a two-stage synchronizer before software can read them. The alternate sources come from other blocks on the chip and enter as plain input vectors. After reset every line routes to alternate 0 and every direction bit is set, so no pad drives until software clears a direction bit.

Routing codes need 32 bits for sixteen lines, so they are split over two addresses. One address holds lines 0 to 7 and the other holds lines 8 to 15.

Top module: `gpio_mux_regs`

## Requirements
- R1: After reset, both routing registers read 0x0000, the direction mask reads 0xFFFF, output data reads 0x0000, and pad_oe is all zero.
- R2: Line i's routing code sits in bits [2(i mod 8)+1 : 2(i mod 8)]. The word at offset 0x200 holds lines 0–7 and the word at offset 0x204 holds lines 8–15. Both words read back what was written, and a write to one leaves the other unchanged.
- R3: With routing code 1, pad_out[i] equals bit i of the output-data register (offset 0x20C), and pad_oe[i] is the inverse of direction bit i.
- R4: With routing code 0, pad_out[i] follows alt0_out[i] and pad_oe[i] is alt0_oe[i] AND NOT direction bit i. With code 2, both follow alt2_out and alt2_oe in the same way.
- R5: With routing code 3 (input-only alternate), pad_oe[i] and pad_out[i] are both 0 whatever the direction bit or alternate inputs.
- R6: The direction mask at offset 0x208 reads back what was written. A set bit forces pad_oe[i] to 0 under every routing code.
- R7: A read of offset 0x210 returns pad_in as it stood two rising clock edges earlier.
- R8: A write to offset 0x210, or to any offset other than 0x200, 0x204, 0x208 and 0x20C, changes no register and no pad output. A read of any offset other than these five returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| alt0_out | input | 16 | Alternate source 0 data |
| alt0_oe | input | 16 | Alternate source 0 enable |
| alt2_out | input | 16 | Alternate source 2 data |
| alt2_oe | input | 16 | Alternate source 2 enable |

## Verification
Random rounds mix the four routing codes per line with random direction masks and random alternate data and enables. A pad mismatch therefore shows whether the wrong source was chosen, the wrong enable was used, or the direction mask was ignored. Writes also go to unmapped and misaligned offsets and to the input register. These separate a decoder that ignores low address bits or accepts the read-only word from a correct one. Directed steps on pad_in read the input word after one edge and again after two, which tells a two-stage synchronizer from a one-stage one or a missing one.

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs #(
  parameter int ADDR_W     = 12,
  parameter int SEL_LO_OFS = 'h200,
  parameter int SEL_HI_OFS = 'h204,
  parameter int DIR_OFS    = 'h208,
  parameter int DOUT_OFS   = 'h20C,
  parameter int DIN_OFS    = 'h210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [15:0]       pad_in,
  output logic [15:0]       pad_out,
  output logic [15:0]       pad_oe,
  input  logic [15:0]       alt0_out,
  input  logic [15:0]       alt0_oe,
  input  logic [15:0]       alt2_out,
  input  logic [15:0]       alt2_oe
);
  localparam int LINES = 16;
  localparam int HALF  = LINES / 2;

  logic [2*LINES-1:0] route_q;
  logic [LINES-1:0]   dir_q, dout_q, sync1_q, sync2_q;

  logic hit_lo, hit_hi, hit_dir, hit_dout, hit_din;
  assign hit_lo   = bus_addr == ADDR_W'(SEL_LO_OFS);
  assign hit_hi   = bus_addr == ADDR_W'(SEL_HI_OFS);
  assign hit_dir  = bus_addr == ADDR_W'(DIR_OFS);
  assign hit_dout = bus_addr == ADDR_W'(DOUT_OFS);
  assign hit_din  = bus_addr == ADDR_W'(DIN_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= '0;
      dir_q   <= '1;
      dout_q  <= '0;
    end else if (bus_wr) begin
      if (hit_lo)   route_q[2*HALF-1:0]       <= bus_wdata;
      if (hit_hi)   route_q[2*LINES-1:2*HALF] <= bus_wdata;
      if (hit_dir)  dir_q                     <= bus_wdata;
      if (hit_dout) dout_q                    <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign bus_rdata = hit_lo   ? route_q[2*HALF-1:0] :
                     hit_hi   ? route_q[2*LINES-1:2*HALF] :
                     hit_dir  ? dir_q :
                     hit_dout ? dout_q :
                     hit_din  ? sync2_q : '0;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [1:0] code;
    logic       src_d, src_e;
    assign code  = route_q[2*i +: 2];
    assign src_d = (code == 2'd0) ? alt0_out[i] :
                   (code == 2'd1) ? dout_q[i]   :
                   (code == 2'd2) ? alt2_out[i] : 1'b0;
    assign src_e = (code == 2'd0) ? alt0_oe[i] :
                   (code == 2'd1) ? 1'b1       :
                   (code == 2'd2) ? alt2_oe[i] : 1'b0;
    assign pad_out[i] = src_d;
    assign pad_oe[i]  = src_e & ~dir_q[i];

    a_r5_input_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'd3) |-> (!pad_oe[i] && !pad_out[i]));
    a_r6_dir_releases: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q[i] |-> !pad_oe[i]);
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n)            warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '1 && dout_q == '0 && route_q == '0 && pad_oe == '0));
  a_r7_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync2_q == $past(pad_in, 2)));
  a_r2_halves_independent: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_hi) |=> $stable(route_q[2*HALF-1:0]));
  a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_lo && !hit_hi && !hit_dir && !hit_dout) |=>
      ($stable(route_q) && $stable(dir_q) && $stable(dout_q)));
  a_r3_dout_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_dout) |=> (dout_q == $past(bus_wdata)));
endmodule

// File: tb/gpio_mux_regs_test.sv
module gpio_mux_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pad_in = '0, pad_out, pad_oe;
  logic [15:0] alt0_out = '0, alt0_oe = '0, alt2_out = '0, alt2_oe = '0;

  gpio_mux_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt0_out(alt0_out), .alt0_oe(alt0_oe),
    .alt2_out(alt2_out), .alt2_oe(alt2_oe));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] m_route;
  logic [15:0] m_dir, m_dout, h1, h2;

  always @(posedge clk) begin
    if (!rst_n) begin h1 <= '0; h2 <= '0; end
    else begin h1 <= pad_in; h2 <= h1; end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [11:0] a);
    case (a)
      12'h200: return m_route[15:0];
      12'h204: return m_route[31:16];
      12'h208: return m_dir;
      12'h20C: return m_dout;
      12'h210: return h2;
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] exp_pad();
    logic [15:0] o, e;
    for (int i = 0; i < 16; i++) begin
      case (m_route[2*i +: 2])
        2'd0: begin o[i] = alt0_out[i]; e[i] = alt0_oe[i]; end
        2'd1: begin o[i] = m_dout[i];   e[i] = 1'b1;       end
        2'd2: begin o[i] = alt2_out[i]; e[i] = alt2_oe[i]; end
        default: begin o[i] = 1'b0; e[i] = 1'b0; end
      endcase
      if (m_dir[i]) e[i] = 1'b0;
    end
    return {e, o};
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    case (a)
      12'h200: m_route[15:0]  = d;
      12'h204: m_route[31:16] = d;
      12'h208: m_dir  = d;
      12'h20C: m_dout = d;
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [11:0] a);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp_read(a));
  endtask

  task automatic pad_check(input string tag);
    logic [31:0] p;
    p = exp_pad();
    check({tag, " pad_out"}, pad_out, p[15:0]);
    check({tag, " pad_oe"}, pad_oe, p[31:16]);
  endtask

  function automatic logic [11:0] pick_addr(input int unsigned r);
    case (r % 8)
      0: return 12'h200;
      1: return 12'h204;
      2: return 12'h208;
      3: return 12'h20C;
      4: return 12'h210;
      5: return 12'h202;
      6: return 12'h400 | 12'(r[7:2] << 2);
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_route = '0; m_dir = '1; m_dout = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    read_check("R1 route lo", 12'h200);
    read_check("R1 route hi", 12'h204);
    read_check("R1 dir", 12'h208);
    read_check("R1 dout", 12'h20C);
    check("R1 pad_oe", pad_oe, 16'h0000);

    bus_write(12'h200, 16'h5555);
    read_check("R2 lo readback", 12'h200);
    read_check("R2 hi untouched", 12'h204);
    bus_write(12'h204, 16'hFFFF);
    read_check("R2 hi readback", 12'h204);
    read_check("R2 lo untouched", 12'h200);
    bus_write(12'h208, 16'h00F0);
    read_check("R6 dir readback", 12'h208);
    bus_write(12'h20C, 16'hA5C3);
    read_check("R3 dout readback", 12'h20C);
    pad_check("R5 code3 hi lines / R3 code1 lo lines");

    bus_write(12'h208, 16'h0000);
    bus_write(12'h204, 16'hAAAA);
    alt2_out = 16'hF0F0; alt2_oe = 16'h3C3C; #1;
    pad_check("R4 code2");
    bus_write(12'h200, 16'h0000);
    alt0_out = 16'h1234; alt0_oe = 16'h00FF; #1;
    pad_check("R4 code0");

    bus_write(12'h210, 16'hFFFF);
    read_check("R8 din write ignored route", 12'h200);
    pad_check("R8 after din write");
    bus_write(12'h20E, 16'hFFFF);
    read_check("R8 misaligned write dir", 12'h208);
    read_check("R8 unmapped read", 12'h20E);
    read_check("R8 unmapped read 0x300", 12'h300);

    @(negedge clk); pad_in = 16'h0000;
    @(negedge clk); @(negedge clk);
    pad_in = 16'hBEEF;
    @(negedge clk);
    bus_addr = 12'h210; #1;
    check("R7 one edge", bus_rdata, 16'h0000);
    @(negedge clk);
    #1;
    check("R7 two edges", bus_rdata, 16'hBEEF);

    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      a = pick_addr($urandom);
      alt0_out = 16'($urandom); alt0_oe = 16'($urandom);
      alt2_out = 16'($urandom); alt2_oe = 16'($urandom);
      pad_in = 16'($urandom);
      bus_write(a, 16'($urandom));
      pad_check("R3 R4 R5 R6 random");
      read_check("R2 R7 R8 random read", pick_addr($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule